// File: doc/BRIEF.md
# Load/Store Byte-Lane and Alignment Unit

This unit sits between the load/store stage of a 32-bit core and a byte-addressed memory bus whose data path is one word wide. A request gives an address, an access size, a direction, write data, a signed flag for loads and a run-time endianness mode. The unit checks that the access is naturally aligned. An access that is not aligned is turned into an abort pulse and never reaches the bus. An accepted access appears on the bus one cycle later, with a word-aligned address. A store also carries byte enables and write data moved onto the correct byte lanes.

For a load, the memory returns a whole 32-bit word in the cycle the bus request is presented. The unit picks the addressed bytes out of that word, puts them in register order and widens them to 32 bits with zero or sign extension. Three byte-ordering models can be selected per access: little-endian, word-invariant big-endian and byte-invariant big-endian.

Top module: `lsu_lane_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busValid, accessAbort, busWrite, busByteEn and busWData are zero.
- R2: reqSize encodes 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. A doubleword cannot be sent as one beat, so it always aborts. A byte access never aborts.
- R3: A halfword with reqAddr[0]=1, or a word with reqAddr[1:0]≠0, raises accessAbort for one cycle in the cycle after the request. In that cycle busValid is 0 and busByteEn is 0, so nothing is written.
- R4: An accepted request drives busValid high for exactly the next cycle. In that cycle busWrite equals reqWrite and busAddr equals reqAddr with bits [1:0] cleared.
- R5: On a store, busByteEn has one bit set for a byte, two adjacent bits for a halfword and all four bits for a word. Bit k enables data bits [8k+7:8k].
- R6: Mode 0 (little-endian): register byte i of the store or load goes to or from lane reqAddr[1:0]+i. Store lanes outside the access are driven zero.
- R7: Mode 1 (word-invariant big-endian): a byte uses lane 3−reqAddr[1:0] and a halfword starts at lane 2−reqAddr[1:0]. Register bytes are in ascending lane order, and a word is handled as in mode 0.
- R8: Mode 2 (byte-invariant big-endian): lanes are enabled as in mode 0, but register byte i maps to lane reqAddr[1:0]+n−1−i, where n is the access width in bytes. This applies to both loads and stores.
- R9: Mode 3 is reserved and behaves exactly like mode 0.
- R10: In the cycle a load is presented on the bus, loadData is the extracted value. Bytes and halfwords are sign-extended when reqSigned was set and zero-extended otherwise. In any other cycle loadData is zero.
- R11: On a load cycle busByteEn and busWData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Access size code |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSigned | input | 1 | Sign-extend a sub-word load |
| reqWData | input | 32 | Store data in register order |
| endianMode | input | 2 | Byte-ordering model for this access |
| rdWord | input | 32 | Word returned by memory in the bus cycle |
| busValid | output | 1 | Bus transfer presented |
| busWrite | output | 1 | Bus transfer is a store |
| busAddr | output | ADDR_W | Word-aligned bus address |
| busByteEn | output | 4 | Per-lane write enables |
| busWData | output | 32 | Lane-steered store data |
| accessAbort | output | 1 | Alignment abort pulse |
| loadData | output | 32 | Extended load result |

## Verification
The alignment check and the lane steering work on the same request in the same cycle. A misaligned store is the case where both matter together: the abort must win, and the enables computed for it must not reach the bus. The bench goes through every combination of mode, size, low address bits, direction, sign flag and two data patterns. For each access it checks the abort, the bus strobes, the enables, the steered data and the load result against byte-by-byte arithmetic, so a misaligned store that leaks an enable is reported next to its expected zero.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    END_LITTLE   = 2'd0,
    END_BIG_WORD = 2'd1,
    END_BIG_BYTE = 2'd2,
    END_RSVD     = 2'd3
  } endian_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              go;
    logic              write;
    logic              abort;
    logic              sext;
    logic              reverse;
    logic [LANE_W-1:0] base;
    logic [LANE_W:0]   nBytes;
  } laneCtl_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [1:0]        endianMode,
  output laneCtl_t          curCtl,
  output laneCtl_t          heldCtl,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              accessAbort
);
  logic [LANE_W:0]   nBytes;
  logic [LANE_W-1:0] laneOff;
  logic [LANE_W-1:0] flipMask;
  logic              misaligned;

  assign laneOff = reqAddr[LANE_W-1:0];

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: nBytes = 3'd1;
      SZ_HALF: nBytes = 3'd2;
      SZ_WORD: nBytes = 3'd4;
      default: nBytes = 3'd0;
    endcase
  end

  // width-1 mask of the low address bits; 4 wraps to 0 so the mask is 3
  assign misaligned = (nBytes == '0) ||
                      ((laneOff & (nBytes[LANE_W-1:0] - LANE_W'(1))) != '0);

  always_comb begin
    flipMask = '0;
    if (endian_e'(endianMode) == END_BIG_WORD) begin
      flipMask = 2'(3'(LANES) - nBytes);
    end
  end

  always_comb begin
    curCtl.go      = reqValid && !misaligned;
    curCtl.abort   = reqValid && misaligned;
    curCtl.write   = reqWrite;
    curCtl.sext    = reqSigned;
    curCtl.reverse = (endian_e'(endianMode) == END_BIG_BYTE);
    curCtl.base    = laneOff ^ flipMask;
    curCtl.nBytes  = nBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCtl     <= '0;
      busValid    <= 1'b0;
      busWrite    <= 1'b0;
      accessAbort <= 1'b0;
      busAddr     <= '0;
    end else begin
      heldCtl     <= curCtl;
      busValid    <= curCtl.go;
      busWrite    <= curCtl.go && reqWrite;
      accessAbort <= curCtl.abort;
      if (curCtl.go) begin
        busAddr <= {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/lsu_data.sv
module lsu_data
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          curCtl,
  input  laneCtl_t          heldCtl,
  input  logic [WORD_W-1:0] reqWData,
  input  logic [WORD_W-1:0] rdWord,
  output logic [LANES-1:0]  busByteEn,
  output logic [WORD_W-1:0] busWData,
  output logic [WORD_W-1:0] loadData
);
  logic [LANES-1:0][7:0] steerByte;
  logic [LANES-1:0]      laneEn;
  logic [LANES-1:0][7:0] rawByte;
  logic [LANES-1:0][7:0] valByte;
  logic [LANE_W-1:0]     topIdx;
  logic                  signFill;

  // store path: lane L takes register byte srcIdx
  for (genvar L = 0; L < LANES; L++) begin : g_wlane
    logic [LANE_W-1:0] offs;
    logic [LANE_W-1:0] srcIdx;
    logic              inWin;
    assign offs   = LANE_W'(L) - curCtl.base;
    assign inWin  = {1'b0, offs} < curCtl.nBytes;
    assign srcIdx = curCtl.reverse ? (curCtl.nBytes[LANE_W-1:0] - LANE_W'(1) - offs) : offs;
    assign steerByte[L] = inWin ? reqWData[8*srcIdx +: 8] : 8'h00;
    assign laneEn[L]    = inWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busByteEn <= '0;
      busWData  <= '0;
    end else if (curCtl.go && curCtl.write) begin
      busByteEn <= laneEn;
      busWData  <= steerByte;
    end else begin
      busByteEn <= '0;
      busWData  <= '0;
    end
  end

  // load path: register byte I comes from lane laneSel
  assign topIdx   = heldCtl.nBytes[LANE_W-1:0] - LANE_W'(1);
  assign signFill = heldCtl.sext && rawByte[topIdx][7];

  for (genvar I = 0; I < LANES; I++) begin : g_rbyte
    logic [LANE_W-1:0] laneSel;
    logic              present;
    assign present = (LANE_W+1)'(I) < heldCtl.nBytes;
    assign laneSel = heldCtl.reverse
                   ? (heldCtl.base + heldCtl.nBytes[LANE_W-1:0] - LANE_W'(1) - LANE_W'(I))
                   : (heldCtl.base + LANE_W'(I));
    assign rawByte[I] = rdWord[8*laneSel +: 8];
    assign valByte[I] = present ? rawByte[I] : {8{signFill}};
  end

  assign loadData = (heldCtl.go && !heldCtl.write) ? valByte : '0;
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSigned,
  input  logic [31:0]       reqWData,
  input  logic [1:0]        endianMode,
  input  logic [31:0]       rdWord,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busByteEn,
  output logic [31:0]       busWData,
  output logic              accessAbort,
  output logic [31:0]       loadData
);
  laneCtl_t curCtl;
  laneCtl_t heldCtl;

  lsu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqSigned  (reqSigned),
    .endianMode (endianMode),
    .curCtl     (curCtl),
    .heldCtl    (heldCtl),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .accessAbort(accessAbort)
  );

  lsu_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .curCtl   (curCtl),
    .heldCtl  (heldCtl),
    .reqWData (reqWData),
    .rdWord   (rdWord),
    .busByteEn(busByteEn),
    .busWData (busWData),
    .loadData (loadData)
  );
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busByteEn,
  input logic              accessAbort,
  input logic [31:0]       loadData
);
  // R3
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessAbort |-> (!busValid && busByteEn == 4'b0));

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd2 && reqAddr[1:0] != 2'd0) |=> accessAbort);

  // R2
  dword_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3) |=> (accessAbort && !busValid));

  // R2
  byte_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0) |=> (busValid && !accessAbort));

  // R4
  bus_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid || accessAbort) |-> $past(reqValid));

  // R4
  bus_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[1:0] == 2'b00));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> ($countones(busByteEn) == 1 ||
                                $countones(busByteEn) == 2 ||
                                $countones(busByteEn) == 4));

  // R11
  read_no_be_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |-> (busByteEn == 4'b0));

  // R10
  idle_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |-> (loadData == 32'b0));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqSize    (reqSize),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busByteEn  (busByteEn),
  .accessAbort(accessAbort),
  .loadData   (loadData)
);

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqSigned = 1'b0;
  logic [31:0] reqWData = '0;
  logic [1:0]  endianMode = '0;
  logic [31:0] rdWord = '0;
  logic        busValid, busWrite, accessAbort;
  logic [31:0] busAddr, busWData, loadData;
  logic [3:0]  busByteEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsu_lane_unit #(.ADDR_W(32)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqSigned(reqSigned),
    .reqWData(reqWData), .endianMode(endianMode), .rdWord(rdWord),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWData(busWData), .accessAbort(accessAbort),
    .loadData(loadData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input int mode, input int size, input int lo,
                          input bit wr, input bit sgn, input logic [31:0] wd,
                          input logic [31:0] rd, input logic [31:0] addr);
    int n;
    int base;
    bit mis;
    logic [3:0]  expBe = '0;
    logic [31:0] expW = '0;
    logic [31:0] expL = '0;
    string tag;
    n   = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
    mis = (n == 0) || ((lo % n) != 0);
    base = (mode == 1) ? (4 - n - lo) : lo;
    tag = (mode == 0) ? "R6" : (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R9";
    if (!mis) begin
      for (int i = 0; i < n; i++) begin
        int lane;
        lane = (mode == 2) ? (base + n - 1 - i) : (base + i);
        expBe[lane] = 1'b1;
        expW[lane*8 +: 8] = wd[i*8 +: 8];
        expL[i*8 +: 8] = rd[lane*8 +: 8];
      end
      if (sgn && n < 4 && expL[8*n-1]) expL = expL | ~((32'h1 << (8*n)) - 32'h1);
      if (wr) expL = '0;
      else begin expBe = '0; expW = '0; end
    end

    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = 2'(size); reqWrite = wr;
    reqSigned = sgn; reqWData = wd; endianMode = 2'(mode);
    @(negedge clk);
    reqValid = 1'b0; reqWData = ~wd; reqAddr = ~addr; rdWord = rd;
    #1;
    check(size == 3 ? "R2" : "R3", "abort", 32'(accessAbort), 32'(mis));
    check("R4", "busValid", 32'(busValid), 32'(!mis));
    if (!mis) begin
      check("R4", "busWrite", 32'(busWrite), 32'(wr));
      check("R4", "busAddr", busAddr, addr & ~32'h3);
    end
    if (wr) begin
      check(mode == 0 ? "R5" : tag, "byteEn", 32'(busByteEn), 32'(expBe));
      check(tag, "wdata", busWData, expW);
    end else begin
      check("R11", "read byteEn", 32'(busByteEn), 32'(expBe));
      check("R11", "read wdata", busWData, 32'h0);
    end
    check(wr ? "R10" : tag, "loadData", loadData, mis ? 32'h0 : expL);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] wPat [2];
    logic [31:0] rPat [2];
    int iter = 0;
    wPat[0] = 32'hA1B2_C3D4; wPat[1] = 32'h1E8F_705C;
    rPat[0] = 32'hF381_7E05; rPat[1] = 32'h0C7F_91E8;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "busValid rst", 32'(busValid), 32'h0);
    check("R1", "abort rst", 32'(accessAbort), 32'h0);
    check("R1", "byteEn rst", 32'(busByteEn), 32'h0);
    check("R1", "wdata rst", busWData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busWrite post", 32'(busWrite), 32'h0);
    check("R1", "busValid post", 32'(busValid), 32'h0);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 4; a++)
          for (int w = 0; w < 2; w++)
            for (int g = 0; g < 2; g++)
              for (int p = 0; p < 2; p++) begin
                doAccess(m, s, a, w[0], g[0], wPat[p], rPat[p],
                         32'h4000_0000 + 32'(iter) * 32'd16 + 32'(a));
                iter++;
              end
    @(negedge clk);
    check("R10", "idle loadData", loadData, 32'h0);
    check("R4", "idle busValid", 32'(busValid), 32'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule